// File: doc/BRIEF.md
# Address Latch with Step Unit

This block is the address path of a 16-bit processor. A holding register takes a value from a shared two-way internal address bus. A step unit adds +1, subtracts 1, or passes that held value through unchanged. An output selector puts one of three values on the address output: the stepped value, the held value, or the live bus value.

The stepped value can be driven back onto the internal bus through a tri-state enable. When the holding register loads in the same cycle, the block steps itself, as a program counter does. A narrow-count mode steps only the low six bits, for a refresh or instruction counter. A clear input forces the stepped value to zero. A flag output reports when the address output equals one.

The path from the holding register and the controls to the outputs is combinational. The holding register changes only on a rising clock edge.

Top module: `addr_latch_step`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the holding register is cleared to 0x0000.
- R2: On a rising edge with `rst` low and `ld_en` high, the holding register takes the value on `addr_bus`. With `ld_en` low it keeps its value, and outputs derived from it stay unchanged.
- R3: The stepped value is `held + cin` when `dir_dn` is 0 and `held - cin` when `dir_dn` is 1. With `cin` at 0 the held value passes through unchanged.
- R4: Full-width stepping wraps modulo 2^16: 0xFFFF + 1 gives 0x0000 and 0x0000 - 1 gives 0xFFFF.
- R5: With `lo6_mode` high, only bits 5..0 step, wrapping 0x3F to 0x00 upward and 0x00 to 0x3F downward. Bits 15..6 keep the held value.
- R6: With `zero_force` high, the stepped value is 0x0000 whatever `dir_dn`, `cin` and `lo6_mode` are.
- R7: `addr_out` shows the stepped value when `sel_step` is 1. Otherwise it shows the held value when `sel_held` is 1. With both at 0 it shows the value on `addr_bus`.
- R8: With `bus_drv` high, the block drives the stepped value onto `addr_bus`. With `bus_drv` low it leaves `addr_bus` at high impedance, so another driver's value is seen on it.
- R9: `is_one` is 1 exactly when `addr_out` equals 0x0001.
- R10: With `bus_drv` and `ld_en` both high, the holding register loads its own stepped value, so repeated cycles count up or down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr_bus | inout | 16 | Shared two-way internal address bus |
| ld_en | input | 1 | Load holding register from the bus |
| bus_drv | input | 1 | Drive the stepped value onto the bus |
| dir_dn | input | 1 | Step direction: 0 up, 1 down |
| cin | input | 1 | Step size: 1 or 0 |
| lo6_mode | input | 1 | Step only the low six bits |
| zero_force | input | 1 | Force the stepped value to zero |
| sel_step | input | 1 | Output the stepped value (highest priority) |
| sel_held | input | 1 | Output the held value |
| addr_out | output | 16 | Address output |
| is_one | output | 1 | High when addr_out equals 0x0001 |

## Verification
The hardest case to reach is the self-feeding loop. The block drives the bus and loads from it in the same cycle, so the bench must release its own bus driver at that moment. The bench does this by turning off its driver whenever `bus_drv` is high, and then runs several back-to-back steps up and down. It also runs steps across the 0xFFFF/0x0000 boundary and the six-bit 0x3F/0x00 boundary. To show that the bus is at high impedance, the bench drives the bus itself with both selects low and reads the value back on `addr_out`.

// File: rtl/addr_pkg.sv
package addr_pkg;
  // Source chosen for the address output
  typedef enum logic [1:0] {
    SRC_BUS  = 2'd0,
    SRC_HELD = 2'd1,
    SRC_STEP = 2'd2
  } addr_src_e;
endpackage

// File: rtl/addr_hold_reg.sv
module addr_hold_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (ld_en) q <= d;
  end
endmodule

// File: rtl/addr_stepper.sv
module addr_stepper #(
  parameter int AW    = 16,
  parameter int LIM_W = 6
) (
  input  logic [AW-1:0] base,
  input  logic          dir_dn,
  input  logic          cin,
  input  logic          lo6_mode,
  input  logic          zero_force,
  output logic [AW-1:0] result
);
  localparam logic [AW-1:0] STEP_ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] step_v;
  logic [AW-1:0] full_v;
  logic [AW-1:0] narrow_v;

  assign step_v = cin ? STEP_ONE : '0;
  assign full_v = dir_dn ? (base - step_v) : (base + step_v);

  generate
    if (LIM_W < AW) begin : g_narrow
      logic [LIM_W-1:0] lo_step;
      logic [LIM_W-1:0] lo_v;
      assign lo_step  = {{(LIM_W-1){1'b0}}, cin};
      assign lo_v     = dir_dn ? (base[LIM_W-1:0] - lo_step)
                               : (base[LIM_W-1:0] + lo_step);
      assign narrow_v = {base[AW-1:LIM_W], lo_v};
    end else begin : g_full
      assign narrow_v = full_v;
    end
  endgenerate

  always_comb begin
    if (zero_force)    result = '0;
    else if (lo6_mode) result = narrow_v;
    else               result = full_v;
  end
endmodule

// File: rtl/addr_out_mux.sv
module addr_out_mux
  import addr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          sel_step,
  input  logic          sel_held,
  input  logic [AW-1:0] step_v,
  input  logic [AW-1:0] held_v,
  input  logic [AW-1:0] bus_v,
  output logic [AW-1:0] out_v
);
  addr_src_e src;

  always_comb begin
    if (sel_step)      src = SRC_STEP;
    else if (sel_held) src = SRC_HELD;
    else               src = SRC_BUS;
  end

  always_comb begin
    case (src)
      SRC_STEP: out_v = step_v;
      SRC_HELD: out_v = held_v;
      default:  out_v = bus_v;
    endcase
  end
endmodule

// File: rtl/addr_latch_step.sv
module addr_latch_step #(
  parameter int AW    = 16,
  parameter int LIM_W = 6
) (
  input  logic          clk,
  input  logic          rst,
  inout  wire  [AW-1:0] addr_bus,
  input  logic          ld_en,
  input  logic          bus_drv,
  input  logic          dir_dn,
  input  logic          cin,
  input  logic          lo6_mode,
  input  logic          zero_force,
  input  logic          sel_step,
  input  logic          sel_held,
  output logic [AW-1:0] addr_out,
  output logic          is_one
);
  localparam logic [AW-1:0] ADDR_ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] held_q;
  logic [AW-1:0] step_v;

  addr_hold_reg #(.AW(AW)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .ld_en (ld_en),
    .d     (addr_bus),
    .q     (held_q)
  );

  addr_stepper #(.AW(AW), .LIM_W(LIM_W)) u_step (
    .base       (held_q),
    .dir_dn     (dir_dn),
    .cin        (cin),
    .lo6_mode   (lo6_mode),
    .zero_force (zero_force),
    .result     (step_v)
  );

  addr_out_mux #(.AW(AW)) u_mux (
    .sel_step (sel_step),
    .sel_held (sel_held),
    .step_v   (step_v),
    .held_v   (held_q),
    .bus_v    (addr_bus),
    .out_v    (addr_out)
  );

  assign addr_bus = bus_drv ? step_v : 'z;
  assign is_one   = (addr_out == ADDR_ONE);
endmodule

// File: rtl/addr_latch_step_chk.sv
module addr_latch_step_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_bus,
  input logic          ld_en,
  input logic          bus_drv,
  input logic          cin,
  input logic          zero_force,
  input logic          sel_step,
  input logic          sel_held,
  input logic [AW-1:0] addr_out,
  input logic          is_one,
  input logic [AW-1:0] held_q
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (held_q == '0));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> (held_q == $past(addr_bus)));

  // R2
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(held_q));

  // R3
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_step && !cin && !zero_force) |-> (addr_out == held_q));

  // R6
  zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_step && zero_force) |-> (addr_out == '0));

  // R7
  held_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_step && sel_held) |-> (addr_out == held_q));

  // R8
  bus_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_drv && sel_step) |-> (addr_bus == addr_out));

  // R9
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    is_one |-> (addr_out == {{(AW-1){1'b0}}, 1'b1}));
endmodule

bind addr_latch_step addr_latch_step_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .addr_bus   (addr_bus),
  .ld_en      (ld_en),
  .bus_drv    (bus_drv),
  .cin        (cin),
  .zero_force (zero_force),
  .sel_step   (sel_step),
  .sel_held   (sel_held),
  .addr_out   (addr_out),
  .is_one     (is_one),
  .held_q     (held_q)
);

// File: tb/sim_addr_latch_step.sv
`timescale 1ns/1ps
module sim_addr_latch_step;
  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en, bus_drv, dir_dn, cin, lo6_mode, zero_force;
  logic        sel_step, sel_held;
  logic        tb_en;
  logic [15:0] tb_val;
  wire  [15:0] addr_bus;
  logic [15:0] addr_out;
  logic        is_one;

  int checks = 0;
  int errors = 0;
  int m_held = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign addr_bus = tb_en ? tb_val : 'z;

  addr_latch_step u0 (
    .clk(clk), .rst(rst), .addr_bus(addr_bus), .ld_en(ld_en),
    .bus_drv(bus_drv), .dir_dn(dir_dn), .cin(cin), .lo6_mode(lo6_mode),
    .zero_force(zero_force), .sel_step(sel_step), .sel_held(sel_held),
    .addr_out(addr_out), .is_one(is_one)
  );

  function automatic int model_step(int h, bit dn, bit c, bit lim, bit z);
    int s;
    s = dn ? -int'(c) : int'(c);
    if (z) return 0;
    if (lim) return (h & 'hFFC0) | ((h + s) & 'h3F);
    return (h + s) & 'hFFFF;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(string req, bit r, bit ld, bit drv, bit dn, bit c,
                     bit lim, bit z, bit ss, bit sh, logic [15:0] v);
    int adj, busv, eo;
    rst = r; ld_en = ld; bus_drv = drv; dir_dn = dn; cin = c;
    lo6_mode = lim; zero_force = z; sel_step = ss; sel_held = sh;
    tb_en = !drv; tb_val = v;
    #1;
    adj  = model_step(m_held, dn, c, lim, z);
    busv = drv ? adj : int'(v);
    eo   = ss ? adj : (sh ? m_held : busv);
    check(req, "addr_out", int'(addr_out), eo);
    check("R9", "is_one", int'(is_one), int'(eo == 1));
    if (drv) check("R8", "addr_bus", int'(addr_bus), adj);
    @(posedge clk);
    if (r) m_held = 0;
    else if (ld) m_held = busv;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    //   req   r ld drv dn c lim z ss sh value
    cyc("R1", 1, 0, 0, 0, 0, 0, 0, 0, 1, 16'h5555);
    cyc("R1", 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h5555);  // held reads 0000
    // R2 load then R3 up/down/pass
    cyc("R2", 0, 1, 0, 0, 1, 0, 0, 1, 0, 16'h1234);
    cyc("R3", 0, 0, 0, 0, 1, 0, 0, 1, 0, 16'h0000);  // 1235
    cyc("R3", 0, 0, 0, 1, 1, 0, 0, 1, 0, 16'h0000);  // 1233
    cyc("R3", 0, 0, 0, 1, 0, 0, 0, 1, 0, 16'h0000);  // pass 1234
    // R4 wrap
    cyc("R4", 0, 1, 0, 0, 1, 0, 0, 1, 0, 16'hFFFF);
    cyc("R4", 0, 0, 0, 0, 1, 0, 0, 1, 0, 16'h0000);  // 0000
    cyc("R4", 0, 0, 0, 1, 1, 0, 0, 1, 0, 16'h0000);  // FFFE
    cyc("R4", 0, 1, 0, 0, 1, 0, 0, 1, 0, 16'h0000);
    cyc("R4", 0, 0, 0, 1, 1, 0, 0, 1, 0, 16'h0000);  // FFFF
    cyc("R9", 0, 0, 0, 0, 1, 0, 0, 1, 0, 16'h0000);  // 0001 flag
    // R2 hold after enable drops
    cyc("R2", 0, 1, 0, 0, 1, 0, 0, 1, 0, 16'hAA50);
    cyc("R2", 0, 0, 0, 0, 1, 0, 0, 1, 0, 16'h1111);  // AA51
    cyc("R2", 0, 0, 0, 0, 1, 0, 0, 1, 0, 16'h2222);  // still AA51
    // R5 narrow mode wraps
    cyc("R5", 0, 1, 0, 0, 1, 1, 0, 1, 0, 16'h12BF);
    cyc("R5", 0, 0, 0, 0, 1, 1, 0, 1, 0, 16'h0000);  // 1280
    cyc("R5", 0, 1, 0, 1, 1, 1, 0, 1, 0, 16'h3440);
    cyc("R5", 0, 0, 0, 1, 1, 1, 0, 1, 0, 16'h0000);  // 347F
    cyc("R5", 0, 0, 0, 0, 1, 1, 0, 1, 0, 16'h0000);  // 3441
    // R6 clear wins
    cyc("R6", 0, 0, 0, 0, 1, 0, 1, 1, 0, 16'h0000);
    cyc("R6", 0, 0, 0, 1, 1, 1, 1, 1, 0, 16'h0000);
    // R7 select priority
    cyc("R7", 0, 0, 0, 0, 1, 0, 0, 0, 1, 16'h7777);  // held 3440
    cyc("R7", 0, 0, 0, 0, 1, 0, 0, 1, 1, 16'h7777);  // step 3441
    cyc("R7", 0, 0, 0, 0, 1, 0, 0, 0, 0, 16'h7777);  // bus
    cyc("R9", 0, 0, 0, 0, 1, 0, 0, 0, 0, 16'h0001);  // bus 0001
    // R8 drive bus, then release: bench value visible
    cyc("R8", 0, 0, 1, 0, 1, 0, 0, 0, 0, 16'h0000);  // bus shows 3441
    cyc("R8", 0, 0, 0, 0, 1, 0, 0, 0, 0, 16'hC3C3);  // high-z, bench value
    // R10 self-feeding count
    cyc("R10", 0, 1, 1, 0, 1, 0, 0, 0, 1, 16'h0000);
    cyc("R10", 0, 1, 1, 0, 1, 0, 0, 0, 1, 16'h0000);
    cyc("R10", 0, 1, 1, 0, 1, 0, 0, 0, 1, 16'h0000);  // held 3443
    cyc("R10", 0, 1, 1, 1, 1, 0, 0, 0, 1, 16'h0000);
    cyc("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000);  // held 3442
    cyc("R10", 0, 1, 1, 0, 0, 0, 1, 0, 1, 16'h0000);  // load zero
    cyc("R10", 0, 1, 1, 1, 1, 0, 0, 0, 1, 16'h0000);  // held 0000
    cyc("R4",  0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h0000);  // held FFFF
    // R1 reset again mid-run
    cyc("R1", 1, 1, 0, 0, 1, 0, 0, 0, 1, 16'h9999);
    cyc("R1", 0, 0, 0, 0, 1, 0, 0, 1, 0, 16'h0000);  // 0001
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule